// File: doc/BRIEF.md
# Checksummed Command Frame Handler

This block sits behind a byte-wide receive channel and a byte-wide transmit channel (both valid/ready) and turns incoming command frames into control-register updates and reply frames. A frame opens with a zero byte and carries its own total length. The length is followed by a two-byte command identifier (group, index), an optional payload, and a trailing checksum. The checksum weights every byte by its 1-based position. Frames that fail any check are dropped without a reply, and the receiver goes back to hunting for a start byte.

Four control registers are driven from frames: a streaming enable, a sleep flag, a shunt-switch state and a sample-rate code. Read commands fetch their payload from a simple combinational register-read port (address out, 32-bit word in), from the latest sample word, or from the control registers themselves. With streaming on, every sample strobe that finds the transmitter idle sends the four sample bytes raw, most significant first. Any accepted frame stops the stream. The block comes out of reset asleep. While asleep it answers nothing except the wake command, and only the second of two consecutive wake frames is acknowledged.

Top module: `cmd_frame_ctrl`

## Requirements
- R1: A frame is accepted only when its first byte is 0x00, its second byte (total length including the checksum) lies in 5..16, and its last byte matches the checksum. Byte 2 is the command group, byte 3 the command index, and payload bytes 4 onward.
- R2: A frame with a wrong checksum, a length byte out of range, an unknown command or an illegal payload produces no output byte and leaves every control register unchanged.
- R3: The checksum is the sum, modulo 256, of each preceding byte multiplied by its 1-based position. Replies carry a checksum computed the same way.
- R4: Every accepted set command, and the ping command 00 01 (length 5), is acknowledged with the 5-byte frame 00 05 group index checksum.
- R5: Read commands reply with 00, length 5+N, group, index, N payload bytes most significant first, then the checksum. 03 1E 00 returns the rate code (N=1). 01 0B 00 returns the shunt state 0x00/0x01 (N=1). 00 05 00 returns the last sample word (N=4). Any 01 xx frame of length 5 drives rd_addr with xx and returns rd_data (N=4).
- R6: Command 00 0C with payload 0x01 enables streaming and 0x00 disables it. While enabled, each smp_valid strobe seen with the transmitter idle emits the four sample bytes raw, most significant first. Any accepted frame clears the enable.
- R7: Command 00 0D with payload 0x01 is acknowledged and the sleep flag rises only after the last acknowledge byte has been taken. Payload 0x00 is the wake command.
- R8: While asleep, only the wake command is acted on. The first wake frame gets no reply. A second wake frame directly following it is acknowledged, and sleep clears after that acknowledge completes. Any other accepted frame in between restarts the count.
- R9: Command 04 1E carries payload 00 rr and sets the rate code to rr only for rr in 0x04..0x09. Command 02 0B carries payload 00 ss and sets the shunt to off (ss=0x00) or on (ss=0x01).
- R10: A partly received frame is discarded when no byte arrives for TIMEOUT_CYC consecutive cycles.
- R11: After reset the block is asleep, streaming is off, the rate code is 0x04, the shunt is off and out_valid is low.
- R12: While out_valid is high and out_ready low, out_valid stays high and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | 8 | Receive byte |
| in_ready | output | 1 | Receiver can take a byte |
| out_valid | output | 1 | Transmit byte valid |
| out_data | output | 8 | Transmit byte |
| out_ready | input | 1 | Downstream takes the transmit byte |
| rd_addr | output | 8 | Register-read address (command index) |
| rd_data | input | 32 | Register-read data, combinational |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 32 | Sample word |
| stream_en | output | 1 | Streaming enabled |
| sleep | output | 1 | Sleep flag |
| shunt_on | output | 1 | Shunt switch state |
| rate_code | output | 8 | Sample-rate code |

## Verification
The hardest state to reach is the wake sequence. The bench must hold the block asleep, slip a non-wake frame between two wake frames to see the count restart, and only then complete the pair. A directed sequence walks through that order before any other traffic. Sleep entry is checked with the transmitter held stalled, to show the flag stays low while the acknowledge waits and that the waiting byte holds still. Random set frames with random codes and occasional corrupted checksums then run against a bench-side register model, under random output back-pressure.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int DATA_BYTES = 4;
  localparam int DATA_W     = 8 * DATA_BYTES;
  localparam int HDR_BYTES  = 4;
  localparam int MIN_FRAME  = HDR_BYTES + 1;
  localparam int REPLY_MAX  = MIN_FRAME + DATA_BYTES;
  localparam int TXPOS_W    = $clog2(REPLY_MAX + 1);
  localparam int NB_W       = $clog2(DATA_BYTES + 1);

  localparam logic [7:0] SOF       = 8'h00;
  localparam logic [7:0] RATE_LO   = 8'h04;
  localparam logic [7:0] RATE_HI   = 8'h09;

  localparam logic [7:0] G_SYS     = 8'h00;
  localparam logic [7:0] G_INFO    = 8'h01;
  localparam logic [7:0] G_DEVSET  = 8'h02;
  localparam logic [7:0] G_PROFGET = 8'h03;
  localparam logic [7:0] G_PROFSET = 8'h04;
  localparam logic [7:0] I_PING    = 8'h01;
  localparam logic [7:0] I_SAMPLE  = 8'h05;
  localparam logic [7:0] I_STREAM  = 8'h0C;
  localparam logic [7:0] I_POWER   = 8'h0D;
  localparam logic [7:0] I_SHUNT   = 8'h0B;
  localparam logic [7:0] I_RATE    = 8'h1E;

  typedef struct packed {
    logic [7:0] len;
    logic [7:0] grp;
    logic [7:0] idx;
    logic [7:0] arg0;
    logic [7:0] arg1;
  } frame_t;

  typedef struct packed {
    logic              raw;
    logic [7:0]        grp;
    logic [7:0]        idx;
    logic [NB_W-1:0]   nbytes;
    logic [DATA_W-1:0] data;
  } txreq_t;
endpackage

// File: rtl/cfc_rx_parser.sv
module cfc_rx_parser
  import cfc_pkg::*;
#(
  parameter int MAX_LEN     = 16,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       frm_valid,
  output frame_t     frm,
  input  logic       frm_ready
);
  localparam int POS_W = $clog2(MAX_LEN);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

  logic [POS_W-1:0] pos_q, pos_n;
  logic [7:0]       sum_q, sum_n;
  frame_t           fr_q, fr_n;
  logic             hold_q, hold_n;
  logic [TMO_W-1:0] tmo_q, tmo_n;
  logic             take;
  logic [7:0]       weight, wsum;
  logic             at_ck;

  assign in_ready  = !hold_q;
  assign take      = in_valid && !hold_q;
  assign frm_valid = hold_q;
  assign frm       = fr_q;
  assign weight    = 8'(pos_q) + 8'd1;
  assign wsum      = sum_q + in_data * weight;
  assign at_ck     = (8'(pos_q) == fr_q.len - 8'd1);

  always_comb begin
    pos_n  = pos_q;
    sum_n  = sum_q;
    fr_n   = fr_q;
    hold_n = hold_q;
    tmo_n  = tmo_q;
    if (hold_q && frm_ready) hold_n = 1'b0;
    if (take) begin
      tmo_n = '0;
      if (pos_q == '0) begin
        if (in_data == SOF) begin
          pos_n = POS_W'(1);
          sum_n = '0;
          fr_n  = '0;
        end
      end else if (pos_q == POS_W'(1)) begin
        if (in_data >= 8'(MIN_FRAME) && in_data <= 8'(MAX_LEN)) begin
          fr_n.len = in_data;
          sum_n    = wsum;
          pos_n    = POS_W'(2);
        end else begin
          pos_n = '0;
        end
      end else if (at_ck) begin
        pos_n  = '0;
        hold_n = (in_data == sum_q);
      end else begin
        sum_n = wsum;
        pos_n = pos_q + POS_W'(1);
        case (pos_q)
          POS_W'(2): fr_n.grp  = in_data;
          POS_W'(3): fr_n.idx  = in_data;
          POS_W'(4): fr_n.arg0 = in_data;
          POS_W'(5): fr_n.arg1 = in_data;
          default: ;
        endcase
      end
    end else if (pos_q != '0) begin
      if (tmo_q == TMO_W'(TIMEOUT_CYC - 1)) begin
        pos_n = '0;
        tmo_n = '0;
      end else begin
        tmo_n = tmo_q + TMO_W'(1);
      end
    end else begin
      tmo_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      sum_q  <= '0;
      fr_q   <= '0;
      hold_q <= 1'b0;
      tmo_q  <= '0;
    end else begin
      pos_q  <= pos_n;
      hold_q <= hold_n;
      tmo_q  <= tmo_n;
      if (take) begin
        sum_q <= sum_n;
        fr_q  <= fr_n;
      end
    end
  end

  assert_frame_on_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(take));
  assert_len_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (fr_q.len >= 8'(MIN_FRAME) && fr_q.len <= 8'(MAX_LEN)));
  assert_frame_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && !frm_ready |=> hold_q && $stable(fr_q));
  assert_tmo_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q < TMO_W'(TIMEOUT_CYC));
endmodule

// File: rtl/cfc_ctrl.sv
module cfc_ctrl
  import cfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  frame_t            frm,
  output logic              frm_ready,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic [7:0]        rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              req_valid,
  output txreq_t            req,
  input  logic              req_ready,
  input  logic              tx_done,
  output logic              stream_en,
  output logic              sleep,
  output logic              shunt_on,
  output logic [7:0]        rate_code
);
  logic stream_q, stream_n, sleep_q, sleep_n, shunt_q, shunt_n;
  logic armed_q, armed_n, pend_q, pend_n, psleep_q, psleep_n;
  logic [7:0]        rate_q, rate_n;
  logic [DATA_W-1:0] smp_q;

  logic c_ping, c_smp, c_strm, c_pwr, c_info, c_gshunt, c_grate, c_sshunt, c_srate;
  logic known, is_wake, reply, fire, strm_go;
  logic [NB_W-1:0]   r_nb;
  logic [DATA_W-1:0] r_data;

  function automatic logic hit(input frame_t f, input logic [7:0] g, input logic [7:0] i,
                               input int l);
    return f.grp == g && f.idx == i && f.len == 8'(l);
  endfunction

  always_comb begin
    c_ping   = hit(frm, G_SYS, I_PING, MIN_FRAME);
    c_smp    = hit(frm, G_SYS, I_SAMPLE, MIN_FRAME + 1) && frm.arg0 == 8'h00;
    c_strm   = hit(frm, G_SYS, I_STREAM, MIN_FRAME + 1) && frm.arg0[7:1] == 7'd0;
    c_pwr    = hit(frm, G_SYS, I_POWER, MIN_FRAME + 1) && frm.arg0[7:1] == 7'd0;
    c_info   = frm.grp == G_INFO && frm.len == 8'(MIN_FRAME);
    c_gshunt = hit(frm, G_INFO, I_SHUNT, MIN_FRAME + 1) && frm.arg0 == 8'h00;
    c_grate  = hit(frm, G_PROFGET, I_RATE, MIN_FRAME + 1) && frm.arg0 == 8'h00;
    c_sshunt = hit(frm, G_DEVSET, I_SHUNT, MIN_FRAME + 2) && frm.arg0 == 8'h00
               && frm.arg1[7:1] == 7'd0;
    c_srate  = hit(frm, G_PROFSET, I_RATE, MIN_FRAME + 2) && frm.arg0 == 8'h00
               && frm.arg1 >= RATE_LO && frm.arg1 <= RATE_HI;
    known    = c_ping | c_smp | c_strm | c_pwr | c_info | c_gshunt | c_grate
               | c_sshunt | c_srate;
    is_wake  = c_pwr && !frm.arg0[0];
    r_nb     = '0;
    r_data   = '0;
    if (c_smp) begin
      r_nb = NB_W'(DATA_BYTES); r_data = smp_q;
    end else if (c_info) begin
      r_nb = NB_W'(DATA_BYTES); r_data = rd_data;
    end else if (c_gshunt) begin
      r_nb = NB_W'(1); r_data = DATA_W'(shunt_q);
    end else if (c_grate) begin
      r_nb = NB_W'(1); r_data = DATA_W'(rate_q);
    end
  end

  assign rd_addr   = frm.idx;
  assign frm_ready = req_ready && !pend_q;
  assign fire      = frm_valid && frm_ready;
  assign reply     = sleep_q ? (is_wake && armed_q) : known;
  assign strm_go   = stream_q && !sleep_q && smp_valid && req_ready && !pend_q && !frm_valid;
  assign req_valid = (fire && reply) || strm_go;

  always_comb begin
    req.raw    = !frm_valid;
    req.grp    = frm.grp;
    req.idx    = frm.idx;
    req.nbytes = frm_valid ? r_nb : NB_W'(DATA_BYTES);
    req.data   = frm_valid ? r_data : smp_data;
  end

  always_comb begin
    stream_n = stream_q;
    sleep_n  = sleep_q;
    shunt_n  = shunt_q;
    rate_n   = rate_q;
    armed_n  = armed_q;
    pend_n   = pend_q;
    psleep_n = psleep_q;
    if (fire) begin
      stream_n = 1'b0;
      if (sleep_q) begin
        armed_n = is_wake && !armed_q;
      end else begin
        armed_n = 1'b0;
        if (c_strm && frm.arg0[0]) stream_n = 1'b1;
        if (c_sshunt) shunt_n = frm.arg1[0];
        if (c_srate)  rate_n  = frm.arg1;
      end
      if (reply && c_pwr) begin
        pend_n   = 1'b1;
        psleep_n = frm.arg0[0];
      end
    end
    if (pend_q && tx_done) begin
      pend_n  = 1'b0;
      sleep_n = psleep_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stream_q <= 1'b0;
      sleep_q  <= 1'b1;
      shunt_q  <= 1'b0;
      rate_q   <= RATE_LO;
      armed_q  <= 1'b0;
      pend_q   <= 1'b0;
      psleep_q <= 1'b0;
      smp_q    <= '0;
    end else begin
      stream_q <= stream_n;
      sleep_q  <= sleep_n;
      shunt_q  <= shunt_n;
      rate_q   <= rate_n;
      armed_q  <= armed_n;
      pend_q   <= pend_n;
      psleep_q <= psleep_n;
      if (smp_valid) smp_q <= smp_data;
    end
  end

  assign stream_en = stream_q;
  assign sleep     = sleep_q;
  assign shunt_on  = shunt_q;
  assign rate_code = rate_q;

  assert_sleep_nostream_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> !stream_q);
  assert_rate_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q >= RATE_LO && rate_q <= RATE_HI);
  assert_sleep_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sleep_q) |-> $past(tx_done));
  assert_wake_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sleep_q) |-> (!req.raw && req.grp == G_SYS && req.idx == I_POWER));
endmodule

// File: rtl/cfc_tx.sv
module cfc_tx
  import cfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  txreq_t     req,
  output logic       req_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic       done
);
  logic               busy_q, busy_n, raw_q, raw_n;
  logic [TXPOS_W-1:0] pos_q, pos_n, tot_q, tot_n;
  logic [7:0]         grp_q, grp_n, idx_q, idx_n, acc_q, acc_n;
  logic [DATA_W-1:0]  data_q, data_n;
  logic               last, dphase, xfer;
  logic [7:0]         obyte;

  function automatic logic [DATA_W-1:0] align(input logic [DATA_W-1:0] d,
                                              input logic [NB_W-1:0] nb);
    logic [DATA_W-1:0] r;
    r = d;
    for (int k = 0; k < DATA_BYTES; k++) begin
      if (k >= int'(nb)) r = r << 8;
    end
    return r;
  endfunction

  assign last      = (pos_q == tot_q - TXPOS_W'(1));
  assign dphase    = raw_q || (pos_q >= TXPOS_W'(HDR_BYTES) && !last);
  assign xfer      = busy_q && out_ready;
  assign req_ready = !busy_q;
  assign out_valid = busy_q;
  assign out_data  = obyte;
  assign done      = xfer && last;

  always_comb begin
    if (raw_q) begin
      obyte = data_q[DATA_W-1 -: 8];
    end else begin
      case (pos_q)
        TXPOS_W'(0): obyte = SOF;
        TXPOS_W'(1): obyte = 8'(tot_q);
        TXPOS_W'(2): obyte = grp_q;
        TXPOS_W'(3): obyte = idx_q;
        default:     obyte = last ? acc_q : data_q[DATA_W-1 -: 8];
      endcase
    end
  end

  always_comb begin
    busy_n = busy_q;
    raw_n  = raw_q;
    pos_n  = pos_q;
    tot_n  = tot_q;
    grp_n  = grp_q;
    idx_n  = idx_q;
    acc_n  = acc_q;
    data_n = data_q;
    if (!busy_q) begin
      if (req_valid) begin
        busy_n = 1'b1;
        raw_n  = req.raw;
        pos_n  = '0;
        tot_n  = req.raw ? TXPOS_W'(req.nbytes)
                         : TXPOS_W'(req.nbytes) + TXPOS_W'(MIN_FRAME);
        grp_n  = req.grp;
        idx_n  = req.idx;
        acc_n  = '0;
        data_n = align(req.data, req.nbytes);
      end
    end else if (xfer) begin
      acc_n = acc_q + obyte * (8'(pos_q) + 8'd1);
      pos_n = pos_q + TXPOS_W'(1);
      if (dphase) data_n = data_q << 8;
      if (last) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      raw_q  <= 1'b0;
      pos_q  <= '0;
      tot_q  <= '0;
      grp_q  <= '0;
      idx_q  <= '0;
      acc_q  <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_n;
      pos_q  <= pos_n;
      acc_q  <= acc_n;
      data_q <= data_n;
      if (!busy_q) begin
        raw_q <= raw_n;
        tot_q <= tot_n;
        grp_q <= grp_n;
        idx_q <= idx_n;
      end
    end
  end

  assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_reply_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !raw_q && pos_q == TXPOS_W'(1)) |->
      (out_data == 8'(MIN_FRAME) || out_data == 8'(MIN_FRAME + 1)
       || out_data == 8'(REPLY_MAX)));
  assert_sof_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !raw_q && pos_q == '0) |-> out_data == SOF);
endmodule

// File: rtl/cmd_frame_ctrl.sv
module cmd_frame_ctrl
  import cfc_pkg::*;
#(
  parameter int MAX_LEN     = 16,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic [7:0]        rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              stream_en,
  output logic              sleep,
  output logic              shunt_on,
  output logic [7:0]        rate_code
);
  logic   frm_valid, frm_ready, req_valid, req_ready, tx_done;
  frame_t frm;
  txreq_t req;

  cfc_rx_parser #(.MAX_LEN(MAX_LEN), .TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .frm_valid(frm_valid), .frm(frm), .frm_ready(frm_ready)
  );

  cfc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm(frm), .frm_ready(frm_ready),
    .smp_valid(smp_valid), .smp_data(smp_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .req_valid(req_valid), .req(req), .req_ready(req_ready), .tx_done(tx_done),
    .stream_en(stream_en), .sleep(sleep), .shunt_on(shunt_on), .rate_code(rate_code)
  );

  cfc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req(req), .req_ready(req_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .done(tx_done)
  );
endmodule

// File: tb/cmd_frame_ctrl_tb_top.sv
module cmd_frame_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 40;

  typedef logic [7:0] bq_t[$];

  logic        clk, rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [7:0]  in_data, out_data, rd_addr, rate_code;
  logic [31:0] rd_data, smp_data;
  logic        smp_valid, stream_en, sleep, shunt_on;

  int  errors = 0;
  int  checks = 0;
  bit  stall  = 0;
  bit  ended  = 0;
  bq_t rxq;
  bq_t nil;

  cmd_frame_ctrl #(.MAX_LEN(16), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .rd_addr(rd_addr), .rd_data(rd_data), .smp_valid(smp_valid), .smp_data(smp_data),
    .stream_en(stream_en), .sleep(sleep), .shunt_on(shunt_on), .rate_code(rate_code)
  );

  function automatic logic [31:0] rd_model(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, 8'hC3};
  endfunction
  assign rd_data = rd_model(rd_addr);

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = stall ? 1'b0 : (($urandom % 4) != 0);
      #1;
      if (out_valid && out_ready) rxq.push_back(out_data);
    end
  end

  function automatic logic [7:0] cks(input bq_t f);
    logic [7:0] s = 8'h00;
    foreach (f[k]) s = s + f[k] * 8'(k + 1);
    return s;
  endfunction

  function automatic bq_t mk(input logic [7:0] g, input logic [7:0] i, input bq_t pl);
    bq_t f;
    f = {8'h00, 8'(5 + pl.size()), g, i};
    foreach (pl[k]) f.push_back(pl[k]);
    f.push_back(cks(f));
    return f;
  endfunction

  function automatic bq_t w2q(input logic [31:0] w);
    bq_t q;
    q = {w[31:24], w[23:16], w[15:8], w[7:0]};
    return q;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic send_bytes(input bq_t b);
    @(negedge clk);
    foreach (b[k]) begin
      in_valid = 1'b1;
      in_data  = b[k];
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic expect_bytes(input bq_t e, input string rq, input string what);
    bit ok;
    int act, exp;
    repeat (50) @(negedge clk);
    #2;
    ok  = (rxq.size() == e.size());
    act = rxq.size();
    exp = e.size();
    if (ok) begin
      foreach (e[k]) begin
        if (ok && rxq[k] !== e[k]) begin
          ok  = 1'b0;
          act = rxq[k];
          exp = e[k];
        end
      end
    end
    chk(ok, rq, what, act, exp);
    rxq.delete();
  endtask

  task automatic cmd(input logic [7:0] g, input logic [7:0] i, input bq_t pl,
                     input bq_t e, input string rq, input string what);
    send_bytes(mk(g, i, pl));
    expect_bytes(e, rq, what);
  endtask

  task automatic pulse_smp(input logic [31:0] d);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = d;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    bq_t f, e;
    logic [7:0] rate_m;
    logic       shunt_m;
    logic [7:0] sv;
    logic       svv;
    void'($urandom(32'd20240611));
    nil = {};
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; smp_valid = 1'b0; smp_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R11 reset state
    chk(sleep == 1'b1, "R11", "sleep after reset", sleep, 1);
    chk(stream_en == 1'b0, "R11", "stream after reset", stream_en, 0);
    chk(rate_code == 8'h04, "R11", "rate after reset", rate_code, 4);
    chk(shunt_on == 1'b0, "R11", "shunt after reset", shunt_on, 0);
    chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);

    // R8: asleep, non-wake traffic is ignored
    cmd(8'h00, 8'h01, nil, nil, "R8", "ping while asleep");
    cmd(8'h04, 8'h1E, '{8'h00, 8'h07}, nil, "R8", "rate set while asleep");
    chk(rate_code == 8'h04, "R8", "rate unchanged while asleep", rate_code, 4);
    cmd(8'h00, 8'h0C, '{8'h01}, nil, "R8", "stream on while asleep");
    chk(stream_en == 1'b0, "R8", "stream stays off asleep", stream_en, 0);
    // R8: wake, interrupt, wake, wake
    cmd(8'h00, 8'h0D, '{8'h00}, nil, "R8", "first wake silent");
    chk(sleep == 1'b1, "R8", "still asleep after one wake", sleep, 1);
    cmd(8'h00, 8'h01, nil, nil, "R8", "ping between wakes");
    cmd(8'h00, 8'h0D, '{8'h00}, nil, "R8", "wake after break silent");
    chk(sleep == 1'b1, "R8", "count restarted", sleep, 1);
    cmd(8'h00, 8'h0D, '{8'h00}, '{8'h00, 8'h05, 8'h00, 8'h0D, 8'h3E}, "R8",
        "second wake acknowledged");
    chk(sleep == 1'b0, "R8", "awake after wake pair", sleep, 0);

    // R4 ping and R3 checksum example
    chk(cks('{8'h00, 8'h06, 8'h00, 8'h0C, 8'h00}) == 8'h3C, "R3", "bench checksum", 0, 0);
    cmd(8'h00, 8'h01, nil, mk(8'h00, 8'h01, nil), "R4", "ping ack");

    // R9 rate / shunt set
    rate_m = 8'h04; shunt_m = 1'b0;
    cmd(8'h04, 8'h1E, '{8'h00, 8'h07}, mk(8'h04, 8'h1E, nil), "R9", "rate set ack");
    rate_m = 8'h07;
    chk(rate_code == rate_m, "R9", "rate applied", rate_code, rate_m);
    cmd(8'h04, 8'h1E, '{8'h00, 8'h0A}, nil, "R9", "rate code 0x0A rejected");
    chk(rate_code == rate_m, "R9", "rate kept after bad code", rate_code, rate_m);
    cmd(8'h02, 8'h0B, '{8'h00, 8'h01}, mk(8'h02, 8'h0B, nil), "R9", "shunt on ack");
    shunt_m = 1'b1;
    chk(shunt_on == 1'b1, "R9", "shunt applied", shunt_on, 1);

    // R2 bad checksum, R1 bad length and bad start byte
    f = mk(8'h04, 8'h1E, '{8'h00, 8'h05});
    f[f.size() - 1] = f[f.size() - 1] ^ 8'h01;
    send_bytes(f);
    expect_bytes(nil, "R2", "corrupt checksum silent");
    chk(rate_code == rate_m, "R2", "rate kept after corrupt frame", rate_code, rate_m);
    send_bytes('{8'h00, 8'h04, 8'h00, 8'h01});
    expect_bytes(nil, "R1", "length 4 rejected");
    send_bytes('{8'h55, 8'h00, 8'h05, 8'h00, 8'h01, 8'h0E});
    expect_bytes(mk(8'h00, 8'h01, nil), "R1", "junk before start byte");
    cmd(8'h07, 8'h07, nil, nil, "R2", "unknown command silent");

    // R5 reads
    cmd(8'h03, 8'h1E, '{8'h00}, mk(8'h03, 8'h1E, '{rate_m}), "R5", "rate read");
    cmd(8'h01, 8'h0B, '{8'h00}, mk(8'h01, 8'h0B, '{8'h01}), "R5", "shunt read");
    cmd(8'h01, 8'h03, nil, mk(8'h01, 8'h03, w2q(rd_model(8'h03))), "R5", "info read");

    // R6 streaming
    cmd(8'h00, 8'h0C, '{8'h01}, mk(8'h00, 8'h0C, nil), "R6", "stream on ack");
    chk(stream_en == 1'b1, "R6", "stream enabled", stream_en, 1);
    pulse_smp(32'hA1B2C3D4);
    pulse_smp(32'h01020304);
    expect_bytes({w2q(32'hA1B2C3D4), w2q(32'h01020304)}, "R6", "raw stream bytes");
    cmd(8'h00, 8'h05, '{8'h00}, mk(8'h00, 8'h05, w2q(32'h01020304)), "R6",
        "sample read stops stream");
    chk(stream_en == 1'b0, "R6", "stream cancelled", stream_en, 0);
    pulse_smp(32'hDEADBEEF);
    expect_bytes(nil, "R6", "no stream after cancel");

    // R10 timeout
    f = mk(8'h03, 8'h1E, '{8'h00});
    send_bytes('{f[0], f[1], f[2]});
    repeat (10) @(negedge clk);
    send_bytes('{f[3], f[4], f[5]});
    expect_bytes(f.size() > 0 ? mk(8'h03, 8'h1E, '{rate_m}) : nil, "R10", "short gap kept");
    send_bytes('{f[0], f[1], f[2]});
    repeat (TMO + 5) @(negedge clk);
    send_bytes(f);
    expect_bytes(mk(8'h03, 8'h1E, '{rate_m}), "R10", "stale partial dropped");

    // R7 sleep entry waits for the ack; R12 hold under stall
    stall = 1'b1;
    send_bytes(mk(8'h00, 8'h0D, '{8'h01}));
    repeat (20) @(negedge clk);
    #2;
    sv = out_data; svv = out_valid;
    chk(sleep == 1'b0, "R7", "sleep held while ack stalled", sleep, 0);
    repeat (10) @(negedge clk);
    #2;
    chk(svv && out_valid && out_data == sv, "R12", "byte held under stall", out_data, sv);
    stall = 1'b0;
    expect_bytes(mk(8'h00, 8'h0D, nil), "R7", "sleep ack");
    chk(sleep == 1'b1, "R7", "asleep after ack", sleep, 1);
    cmd(8'h00, 8'h0D, '{8'h00}, nil, "R8", "wake one again");
    cmd(8'h00, 8'h0D, '{8'h00}, mk(8'h00, 8'h0D, nil), "R8", "wake two again");

    // random sets against a model (R9, R2, R3)
    for (int n = 0; n < 40; n++) begin
      bit   bad, israte, ok;
      logic [7:0] v;
      israte = ($urandom % 2) == 0;
      bad    = ($urandom % 4) == 0;
      v      = israte ? 8'($urandom % 12) : 8'($urandom % 3);
      f = israte ? mk(8'h04, 8'h1E, '{8'h00, v}) : mk(8'h02, 8'h0B, '{8'h00, v});
      if (bad) f[f.size() - 1] = f[f.size() - 1] + 8'h01;
      ok = !bad && (israte ? (v >= 8'h04 && v <= 8'h09) : (v <= 8'h01));
      if (ok) begin
        if (israte) rate_m = v; else shunt_m = v[0];
        e = israte ? mk(8'h04, 8'h1E, nil) : mk(8'h02, 8'h0B, nil);
      end else begin
        e = nil;
      end
      send_bytes(f);
      expect_bytes(e, "R9", "random set reply");
      chk(rate_code == rate_m, "R9", "random rate model", rate_code, rate_m);
      chk(shunt_on == shunt_m, "R2", "random shunt model", shunt_on, shunt_m);
    end
    cmd(8'h03, 8'h1E, '{8'h00}, mk(8'h03, 8'h1E, '{rate_m}), "R3", "final rate read");

    finish_run();
  end
endmodule